// File: doc/BRIEF.md
# Five-Level Four-Cell Trellis Mapper

This block is the inner trellis-coded modulation stage of a multi-level memory write path. It takes one data byte per handshake and turns it into four cell levels, each in the range 0 to 4, for one group of four cells. Two of the byte's bits drive an 8-state systematic feedback convolutional code of rate 2/3. The encoder's 3-bit output picks one of eight four-dimensional subsets, and the other six bits pick one of the 64 points inside that subset. The redundancy lands only in the trellis bits, so four five-level cells carry the 9 coded bits and no spare cell is needed. Of the 625 possible level tuples, 512 are used.

The subsets are built by splitting in stages. Each cell's levels split into an even set {0,2,4} and an odd set {1,3}. A pair of cells then falls into one of four pair sets according to its parities. A four-dimensional type joins a pair set for cells 0–1 with a pair set for cells 2–3, and each subset is the union of two such types. A frame-start flag, sampled along with an accepted byte, returns the trellis to state zero at the start of a page frame.

Each group takes three cycles: load, map, emit. The input is ready again in the cycle after the levels are shown.

Top module: `tcm_cell_mapper`

## Requirements
- R1: After reset, byte_ready is 1, cells_valid is 0, and the trellis state is zero, so a first byte sent without grp_first is encoded from state zero.
- R2: A byte is accepted on a rising edge where byte_valid and byte_ready are both 1. byte_ready is then 0 for the next two cycles. cells_valid is 1 in exactly the second cycle after acceptance and is 0 otherwise. byte_valid and byte_data while byte_ready is 0 have no effect on any output or on the trellis.
- R3: grp_first has an effect only in a cycle where a byte is accepted. Raised on its own, it leaves the trellis state unchanged.
- R4: Let the state be s = {s2,s1,s0}, u2 = byte_data[7] and u1 = byte_data[6]. The subset code is c = {u2,u1,s0}, with u2 as the MSB. The next state is {s0, s2^u2, s1^u1^s0}.
- R5: Pair sets are numbered 0 = (even,even), 1 = (odd,odd), 2 = (even,odd), 3 = (odd,even). A type is written (x,y): cells 0–1 lie in pair set x and cells 2–3 in pair set y. Code c gives a filled type F and a remainder type S: c0 F(1,1) S(0,0); c1 F(0,1) S(1,0); c2 F(2,2) S(3,3); c3 F(2,3) S(3,2); c4 F(1,3) S(0,2); c5 F(1,2) S(0,3); c6 F(3,1) S(2,0); c7 F(2,1) S(3,0).
- R6: Point index p = byte_data[5:0]. Points 0 to |F|−1 are the members of F, and the points that follow are the first members of S. Both types are taken in lexicographic order of (cell0, cell1, cell2, cell3).
- R7: Every level shown is in 0..4, with cell 0 on cell_lvl0 up to cell 3 on cell_lvl3.
- R8: From any fixed trellis state, with both values of s0, the 512 combinations of code and point give 512 distinct level tuples.
- R9: A byte accepted with grp_first = 1 is encoded from state zero, and the state then advances from zero as R4 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_first | input | 1 | Frame start, qualified by byte acceptance |
| byte_valid | input | 1 | Input byte is valid |
| byte_ready | output | 1 | Mapper can take a byte |
| byte_data | input | 8 | Data byte: [7:6] trellis bits, [5:0] point index |
| cells_valid | output | 1 | Level outputs are valid this cycle |
| cell_lvl0 | output | 3 | Level of cell 0 |
| cell_lvl1 | output | 3 | Level of cell 1 |
| cell_lvl2 | output | 3 | Level of cell 2 |
| cell_lvl3 | output | 3 | Level of cell 3 |

## Verification
The assertions assume that rst_n is asserted before the first data exchange and that grp_first means something only alongside an accepted byte. They also assume cells_valid needs no backpressure, because the block has no output ready. The stimulus changes inputs only on falling edges. It keeps byte_valid high through busy cycles with junk data and junk grp_first, and pulses grp_first by itself in idle gaps, so the paths that should be ignored are driven on purpose. Groups sent in pairs, a frame-start byte with bit 6 set followed by a test byte, reach both values of the state bit that feeds the subset code. This lets the whole 512-point space be swept and checked for duplicates.

// File: rtl/tcm_map_pkg.sv
package tcm_map_pkg;
    localparam int DATA_W    = 8;
    localparam int CODED_W   = 2;
    localparam int UNCODED_W = DATA_W - CODED_W;
    localparam int STATE_W   = 3;
    localparam int CODE_W    = CODED_W + 1;
    localparam int CELLS     = 4;
    localparam int LVL_W     = 3;
    localparam int MAX_LVL   = 4;
    localparam int IDX_W     = 7;

    // pair set: 0 even/even, 1 odd/odd, 2 even/odd, 3 odd/even
    typedef logic [1:0] pair_set_t;

    typedef struct packed {
        pair_set_t hi;   // cells 0-1
        pair_set_t lo;   // cells 2-3
    } quad_type_t;

    typedef enum logic [1:0] {PH_IDLE, PH_MAP, PH_EMIT} phase_e;

    typedef struct packed {
        phase_e                         phase;
        logic [DATA_W-1:0]              data;
        logic [STATE_W-1:0]             trel;
        logic [CELLS-1:0][LVL_W-1:0]    lvl;
    } map_regs_t;

    function automatic logic [3:0] pair_size(input pair_set_t d);
        case (d)
            2'd0:    return 4'd9;
            2'd1:    return 4'd4;
            default: return 4'd6;
        endcase
    endfunction
endpackage

// File: rtl/tcm_trellis_step.sv
module tcm_trellis_step
    import tcm_map_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic [CODED_W-1:0] u,
    output logic [CODE_W-1:0]  code,
    output logic [STATE_W-1:0] nxt
);
    // systematic code: the two input bits pass through, the parity bit comes from state
    assign code = {u, cur[0]};
    assign nxt  = {cur[0], cur[2] ^ u[1], cur[1] ^ u[0] ^ cur[0]};
endmodule

// File: rtl/tcm_subset_lut.sv
module tcm_subset_lut
    import tcm_map_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output quad_type_t        fill_type,
    output quad_type_t        rest_type
);
    always_comb begin
        unique case (code)
            3'd0: begin fill_type = '{2'd1, 2'd1}; rest_type = '{2'd0, 2'd0}; end
            3'd1: begin fill_type = '{2'd0, 2'd1}; rest_type = '{2'd1, 2'd0}; end
            3'd2: begin fill_type = '{2'd2, 2'd2}; rest_type = '{2'd3, 2'd3}; end
            3'd3: begin fill_type = '{2'd2, 2'd3}; rest_type = '{2'd3, 2'd2}; end
            3'd4: begin fill_type = '{2'd1, 2'd3}; rest_type = '{2'd0, 2'd2}; end
            3'd5: begin fill_type = '{2'd1, 2'd2}; rest_type = '{2'd0, 2'd3}; end
            3'd6: begin fill_type = '{2'd3, 2'd1}; rest_type = '{2'd2, 2'd0}; end
            default: begin fill_type = '{2'd2, 2'd1}; rest_type = '{2'd3, 2'd0}; end
        endcase
    end
endmodule

// File: rtl/tcm_pair_map.sv
module tcm_pair_map
    import tcm_map_pkg::*;
(
    input  pair_set_t        d,
    input  logic [3:0]       q,
    output logic [LVL_W-1:0] lv_a,
    output logic [LVL_W-1:0] lv_b
);
    logic [3:0] q_div3, q_mod3;

    always_comb begin
        q_div3 = q / 4'd3;
        q_mod3 = q % 4'd3;
        unique case (d)
            2'd0: begin                      // even x even, 3x3
                lv_a = {q_div3[1:0], 1'b0};
                lv_b = {q_mod3[1:0], 1'b0};
            end
            2'd1: begin                      // odd x odd, 2x2
                lv_a = {1'b0, q[1], 1'b1};
                lv_b = {1'b0, q[0], 1'b1};
            end
            2'd2: begin                      // even x odd, 3x2
                lv_a = {q[2:1], 1'b0};
                lv_b = {1'b0, q[0], 1'b1};
            end
            default: begin                   // odd x even, 2x3
                lv_a = {1'b0, q_div3[0], 1'b1};
                lv_b = {q_mod3[1:0], 1'b0};
            end
        endcase
    end
endmodule

// File: rtl/tcm_point_map.sv
module tcm_point_map
    import tcm_map_pkg::*;
(
    input  quad_type_t                   fill_type,
    input  quad_type_t                   rest_type,
    input  logic [UNCODED_W-1:0]         p,
    output logic [CELLS-1:0][LVL_W-1:0]  lvl
);
    localparam int PAIRS = CELLS / 2;

    logic [IDX_W-1:0] fill_cnt;
    logic [IDX_W-1:0] p_ext;
    logic [IDX_W-1:0] r;
    logic             use_fill;
    quad_type_t       sel;
    pair_set_t        dsel [PAIRS];
    logic [3:0]       qv   [PAIRS];
    logic [LVL_W-1:0] la   [PAIRS];
    logic [LVL_W-1:0] lb   [PAIRS];

    always_comb begin
        fill_cnt = IDX_W'({3'b0, pair_size(fill_type.hi)} * {3'b0, pair_size(fill_type.lo)});
        p_ext    = IDX_W'(p);
        use_fill = p_ext < fill_cnt;
        sel      = use_fill ? fill_type : rest_type;
        r        = use_fill ? p_ext : (p_ext - fill_cnt);
        unique case (sel.lo)
            2'd0: begin qv[0] = 4'(r / 7'd9); qv[1] = 4'(r % 7'd9); end
            2'd1: begin qv[0] = 4'(r / 7'd4); qv[1] = 4'(r % 7'd4); end
            default: begin qv[0] = 4'(r / 7'd6); qv[1] = 4'(r % 7'd6); end
        endcase
        dsel[0] = sel.hi;
        dsel[1] = sel.lo;
    end

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        tcm_pair_map u_pair (
            .d    (dsel[g]),
            .q    (qv[g]),
            .lv_a (la[g]),
            .lv_b (lb[g])
        );
    end

    assign lvl = {lb[1], la[1], lb[0], la[0]};
endmodule

// File: rtl/tcm_cell_mapper.sv
module tcm_cell_mapper
    import tcm_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_first,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    output logic             cells_valid,
    output logic [2:0]       cell_lvl0,
    output logic [2:0]       cell_lvl1,
    output logic [2:0]       cell_lvl2,
    output logic [2:0]       cell_lvl3
);
    map_regs_t r_q, r_d;

    logic [CODE_W-1:0]              code;
    logic [STATE_W-1:0]             trel_next;
    quad_type_t                     fill_type, rest_type;
    logic [CELLS-1:0][LVL_W-1:0]    map_lvl;

    tcm_trellis_step u_trellis (
        .cur  (r_q.trel),
        .u    (r_q.data[DATA_W-1:UNCODED_W]),
        .code (code),
        .nxt  (trel_next)
    );

    tcm_subset_lut u_lut (
        .code      (code),
        .fill_type (fill_type),
        .rest_type (rest_type)
    );

    tcm_point_map u_points (
        .fill_type (fill_type),
        .rest_type (rest_type),
        .p         (r_q.data[UNCODED_W-1:0]),
        .lvl       (map_lvl)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (byte_valid) begin
                    r_d.data  = byte_data;
                    r_d.trel  = grp_first ? '0 : r_q.trel;
                    r_d.phase = PH_MAP;
                end
            end
            PH_MAP: begin
                r_d.lvl   = map_lvl;
                r_d.trel  = trel_next;
                r_d.phase = PH_EMIT;
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{phase: PH_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign byte_ready  = (r_q.phase == PH_IDLE);
    assign cells_valid = (r_q.phase == PH_EMIT);
    assign cell_lvl0   = r_q.lvl[0];
    assign cell_lvl1   = r_q.lvl[1];
    assign cell_lvl2   = r_q.lvl[2];
    assign cell_lvl3   = r_q.lvl[3];

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> !byte_ready);

    a_r2_emit_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready) |=> ##1 cells_valid);

    a_r2_single_emit: assert property (@(posedge clk) disable iff (!rst_n)
        cells_valid |=> (byte_ready && !cells_valid));

    a_r7_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        cells_valid |-> (cell_lvl0 <= 3'(MAX_LVL) && cell_lvl1 <= 3'(MAX_LVL) &&
                         cell_lvl2 <= 3'(MAX_LVL) && cell_lvl3 <= 3'(MAX_LVL)));

    a_r9_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && grp_first) |=> (r_q.trel == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && !byte_valid) |=> $stable(r_q.trel));
endmodule

// File: tb/tcm_cell_mapper_tb.sv
module tcm_cell_mapper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grp_first = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ready, cells_valid;
    logic [2:0] cell_lvl0, cell_lvl1, cell_lvl2, cell_lvl3;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    logic [2:0] st = 3'd0;
    bit  seen [625];
    bit  track_seen = 1'b0;

    always #2 clk = ~clk;

    tcm_cell_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .grp_first(grp_first),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .cells_valid(cells_valid), .cell_lvl0(cell_lvl0), .cell_lvl1(cell_lvl1),
        .cell_lvl2(cell_lvl2), .cell_lvl3(cell_lvl3)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pset(input int a, input int b);
        if (a % 2 == 0 && b % 2 == 0) return 0;
        if (a % 2 == 1 && b % 2 == 1) return 1;
        if (a % 2 == 0) return 2;
        return 3;
    endfunction

    // R5/R6 reference: walk all tuples in lexicographic order
    function automatic logic [11:0] exp_levels(input logic [2:0] c, input logic [5:0] p);
        int fh, fl, sh, sl, k;
        case (c)
            3'd0: begin fh = 1; fl = 1; sh = 0; sl = 0; end
            3'd1: begin fh = 0; fl = 1; sh = 1; sl = 0; end
            3'd2: begin fh = 2; fl = 2; sh = 3; sl = 3; end
            3'd3: begin fh = 2; fl = 3; sh = 3; sl = 2; end
            3'd4: begin fh = 1; fl = 3; sh = 0; sl = 2; end
            3'd5: begin fh = 1; fl = 2; sh = 0; sl = 3; end
            3'd6: begin fh = 3; fl = 1; sh = 2; sl = 0; end
            default: begin fh = 2; fl = 1; sh = 3; sl = 0; end
        endcase
        k = 0;
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < 5; a++)
                for (int b = 0; b < 5; b++)
                    for (int e = 0; e < 5; e++)
                        for (int f = 0; f < 5; f++)
                            if (pset(a, b) == (pass ? sh : fh) && pset(e, f) == (pass ? sl : fl)) begin
                                if (k == int'(p)) return {3'(a), 3'(b), 3'(e), 3'(f)};
                                k++;
                            end
        return 12'hfff;
    endfunction

    // Called at a falling edge with the mapper idle.
    task automatic send(input logic [7:0] b, input bit fs, input bit junk, input int gap);
        logic [2:0]  c;
        logic [11:0] exp, got;
        int idx;
        if (fs) st = 3'd0;                                   // R9
        c   = {b[7], b[6], st[0]};                           // R4
        exp = exp_levels(c, b[5:0]);
        st  = {st[0], st[2] ^ b[7], st[1] ^ b[6] ^ st[0]};   // R4
        byte_data = b; grp_first = fs; byte_valid = 1'b1;
        @(negedge clk);
        chk(byte_ready == 1'b0 && cells_valid == 1'b0, "R2 busy cycle one",
            {byte_ready, cells_valid}, 2'b00);
        byte_valid = junk; grp_first = junk; byte_data = ~b; // R2: ignored while busy
        @(negedge clk);
        byte_valid = 1'b0; grp_first = 1'b0;
        got = {cell_lvl0, cell_lvl1, cell_lvl2, cell_lvl3};
        chk(cells_valid == 1'b1 && byte_ready == 1'b0, "R2 emit cycle",
            {byte_ready, cells_valid}, 2'b01);
        chk(got == exp, "R6 levels", got, exp);
        chk(cell_lvl0 <= 3'd4 && cell_lvl1 <= 3'd4 && cell_lvl2 <= 3'd4 && cell_lvl3 <= 3'd4,
            "R7 range", got, exp);
        if (track_seen) begin
            idx = cell_lvl0 * 125 + cell_lvl1 * 25 + cell_lvl2 * 5 + cell_lvl3;
            if (idx < 625) begin
                chk(!seen[idx], "R8 distinct tuple", got, 0);
                seen[idx] = 1'b1;
            end
        end
        @(negedge clk);
        chk(byte_ready == 1'b1 && cells_valid == 1'b0, "R2 ready again",
            {byte_ready, cells_valid}, 2'b10);
        for (int g = 0; g < gap; g++) begin
            grp_first = 1'b1;                                 // R3: alone, no effect
            @(negedge clk);
        end
        grp_first = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 625; i++) seen[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk(byte_ready == 1'b1 && cells_valid == 1'b0, "R1 in reset",
            {byte_ready, cells_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_ready == 1'b1 && cells_valid == 1'b0, "R1 after reset",
            {byte_ready, cells_valid}, 2'b10);
        // R1: first byte without grp_first uses state zero
        send(8'hC5, 1'b0, 1'b0, 0);
        // R3: grp_first pulses in gaps must not clear state
        send(8'h40, 1'b0, 1'b0, 3);
        send(8'h7F, 1'b0, 1'b1, 2);
        send(8'hFF, 1'b0, 1'b0, 0);
        // R9: directed frame starts
        send(8'h00, 1'b1, 1'b0, 0);
        send(8'h3F, 1'b0, 1'b0, 0);
        // R8: sweep all 512 code/point combinations
        track_seen = 1'b1;
        for (int b = 0; b < 256; b++) send(8'(b), 1'b1, 1'b0, 0);
        for (int b = 0; b < 256; b++) begin
            track_seen = 1'b0;
            send(8'h40, 1'b1, 1'b0, 0);                       // leaves s0 = 1
            track_seen = 1'b1;
            send(8'(b), 1'b0, 1'b0, 0);
        end
        track_seen = 1'b0;
        begin
            int cnt = 0;
            for (int i = 0; i < 625; i++) cnt += int'(seen[i]);
            chk(cnt == 512, "R8 tuple count", cnt, 512);
        end
        // random streams with occasional frame starts
        for (int n = 0; n < 400; n++)
            send(8'($urandom), ($urandom % 8) == 0, 1'($urandom), int'($urandom % 3));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule